// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block is the clocked core of a processor reset supervisor. It watches two reset causes. One is a supply-low flag from an external comparator, and it arrives already synchronized. The other is an active-low manual request from a push-button or from other logic. From these it builds one active-low system reset.

Each cause has its own qualifier:

- The manual request passes through a two-flop synchronizer. It then must stay low for a minimum number of consecutive cycles, so short glitches are rejected.
- The supply flag must stay high for its own qualification count before it counts as a cause.

Both causes feed a single post-release timer. Reset is held for a full timeout period after the last qualified cause clears. A new cause during that period restarts the timer.

Reset is also asserted from power-on. While `rst_ni` is low, and for one full timeout after it rises, the output stays in reset. A parameter selects the output style:

- Push-pull: the output drives both levels.
- Open-drain: the output only ever drives low and releases its enable when idle.

A status output names the cause of the reset in progress.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_ni` is low, reset is asserted and `cause_o` = 1 (power-on). After `rst_ni` rises (between clock edges), reset is released on the TIMEOUT_CYC-th rising edge, and `cause_o` returns to 0 on that same edge.
- R2: A high level on `supply_low_i` qualifies only after it has been sampled high on SUP_QUAL_CYC consecutive rising edges. A shorter high pulse leaves reset deasserted and `cause_o` at 0.
- R3: Suppose `supply_low_i` rises just before edge 1 and is high for M edges (M >= SUP_QUAL_CYC).
  - Reset asserts on edge SUP_QUAL_CYC+1.
  - Reset releases on edge M+1+TIMEOUT_CYC.
- R4: A low level on `mr_ni` is accepted only after MR_ACCEPT_CYC consecutive low samples, following a two-flop synchronizer. A low pulse of MR_ACCEPT_CYC-1 edges has no effect on the output. A low pulse of exactly MR_ACCEPT_CYC edges is accepted.
- R5: Suppose `mr_ni` falls just before edge 1 and is low for N edges (N >= MR_ACCEPT_CYC).
  - Reset asserts on edge MR_ACCEPT_CYC+3.
  - Reset releases on edge N+3+TIMEOUT_CYC, that is, the press length plus a fixed latency plus the timeout.
- R6: Any qualified cause while reset is held restarts the timeout. Release then comes TIMEOUT_CYC edges after the last cause clears, not after the earlier one.
- R7: `cause_o` encodes the reason for the reset in progress: 0 none, 1 power-on, 2 supply, 3 manual.
  - It follows the most recent qualified cause, and supply wins when both are active.
  - It returns to 0 on the edge that releases reset.
- R8: With OPEN_DRAIN = 0, `rst_no` is low exactly while reset is asserted, and `rst_oe_o` is always 1.
- R9: With OPEN_DRAIN = 1, `rst_no` is always 0 and `rst_oe_o` is 1 exactly while reset is asserted, so the pin is high-impedance when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| supply_low_i | input | 1 | Synchronized comparator flag, high when the supply is below threshold |
| mr_ni | input | 1 | Asynchronous active-low manual reset request |
| rst_no | output | 1 | Active-low system reset data |
| rst_oe_o | output | 1 | Output driver enable (always 1 in push-pull style) |
| cause_o | output | 2 | Reason for the current reset (0 none, 1 power-on, 2 supply, 3 manual) |

## Verification
The hardest situation to reach from the ports is a retrigger. A second, different cause must qualify after the first cause has cleared but before its timeout ends. The stimulus presses the manual input, releases it, and then drops the supply while the timer is counting. It places the supply event so that the first release edge falls strictly inside the second hold. The bench checks that reset is still low at the edge where the first release would have occurred. It also checks that the cause switches from manual to supply mid-hold. Both output styles run side by side on shared inputs, so the open-drain enable is compared on every checked cycle.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_POR    = 2'd1,
    CAUSE_SUPPLY = 2'd2,
    CAUSE_MANUAL = 2'd3
  } cause_e;
endpackage

// File: rtl/rst_sup_qual.sv
module rst_sup_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYC    = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic act_o
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);

  logic          req_s;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [SYNC_STAGES-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
    end
    assign req_s = sync_q[SYNC_STAGES-1];
  end else begin : g_nosync
    assign req_s = req_i;
  end

  // counter clears on any inactive sample: only an unbroken run qualifies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!req_s) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_q == CW'(QUAL_CYC - 1)) begin
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;

  AST_QUAL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(req_s)); // R2 R4
  AST_QUAL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_s |=> !act_q); // R3 R5
endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer
  import rst_sup_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 60_000_000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sup_act_i,
  input  logic   mr_act_i,
  output logic   rst_act_o,
  output cause_e cause_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] tcnt_q;
  logic          rst_q;
  cause_e        cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b1;
      tcnt_q  <= '0;
      cause_q <= CAUSE_POR;
    end else if (sup_act_i || mr_act_i) begin
      rst_q   <= 1'b1;
      tcnt_q  <= '0;
      cause_q <= sup_act_i ? CAUSE_SUPPLY : CAUSE_MANUAL;
    end else if (rst_q) begin
      if (tcnt_q == TW'(TIMEOUT_CYC - 1)) begin
        rst_q   <= 1'b0;
        tcnt_q  <= '0;
        cause_q <= CAUSE_NONE;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign rst_act_o = rst_q;
  assign cause_o   = cause_q;

  AST_CAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_act_i || mr_act_i) |=> rst_q); // R6
  AST_RELEASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> (!$past(sup_act_i) && !$past(mr_act_i))); // R3
  AST_CAUSE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_q |-> (cause_q == CAUSE_NONE)); // R7
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC  = 60_000_000,
  parameter int unsigned MR_ACCEPT_CYC = 50,
  parameter int unsigned SUP_QUAL_CYC  = 5000,
  parameter bit          OPEN_DRAIN    = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_low_i,
  input  logic       mr_ni,
  output logic       rst_no,
  output logic       rst_oe_o,
  output logic [1:0] cause_o
);
  logic   mr_act, sup_act, rst_act;
  cause_e cause;

  rst_sup_qual #(.SYNC_STAGES(2), .QUAL_CYC(MR_ACCEPT_CYC)) u_mr_qual (
    .clk_i, .rst_ni, .req_i(~mr_ni), .act_o(mr_act)
  );

  rst_sup_qual #(.SYNC_STAGES(0), .QUAL_CYC(SUP_QUAL_CYC)) u_sup_qual (
    .clk_i, .rst_ni, .req_i(supply_low_i), .act_o(sup_act)
  );

  rst_sup_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .sup_act_i(sup_act), .mr_act_i(mr_act),
    .rst_act_o(rst_act), .cause_o(cause)
  );

  if (OPEN_DRAIN) begin : g_od
    assign rst_no   = 1'b0;
    assign rst_oe_o = rst_act;
  end else begin : g_pp
    assign rst_no   = ~rst_act;
    assign rst_oe_o = 1'b1;
  end

  assign cause_o = cause;

  AST_PIN_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_act || sup_act) |=> (OPEN_DRAIN ? (rst_oe_o && !rst_no) : !rst_no)); // R8 R9
  AST_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == 2'd0) |-> (OPEN_DRAIN ? !rst_oe_o : (rst_no && rst_oe_o))); // R8 R9
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int T = 40;
  localparam int ACC = 5;
  localparam int Q = 3;

  typedef struct {
    int         cyc;
    logic       rst_n;
    logic [1:0] cause;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic pp_rst_n, pp_oe, od_rst_n, od_oe;
  logic [1:0] pp_cause, od_cause;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_supervisor #(.TIMEOUT_CYC(T), .MR_ACCEPT_CYC(ACC), .SUP_QUAL_CYC(Q), .OPEN_DRAIN(1'b0))
  u_rst_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low), .mr_ni(mr_n),
    .rst_no(pp_rst_n), .rst_oe_o(pp_oe), .cause_o(pp_cause)
  );

  rst_supervisor #(.TIMEOUT_CYC(T), .MR_ACCEPT_CYC(ACC), .SUP_QUAL_CYC(Q), .OPEN_DRAIN(1'b1))
  u_rst_supervisor_od (
    .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low), .mr_ni(mr_n),
    .rst_no(od_rst_n), .rst_oe_o(od_oe), .cause_o(od_cause)
  );

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d got=%0h exp=%0h", req, cyc, got, exp);
    end
  endtask

  task automatic check_all(string req, logic rn, logic [1:0] c);
    check({req, " R8 pp rst_no"}, {3'b0, pp_rst_n}, {3'b0, rn});
    check({req, " R8 pp oe"}, {3'b0, pp_oe}, 4'd1);
    check({req, " R9 od oe"}, {3'b0, od_oe}, {3'b0, ~rn});
    check({req, " R9 od data"}, {3'b0, od_rst_n}, 4'd0);
    check({req, " R7 cause"}, {2'b0, pp_cause}, {2'b0, c});
  endtask

  task automatic push(int c, logic rn, logic [1:0] cause);
    exp_t e;
    e.cyc = c; e.rst_n = rn; e.cause = cause;
    q.push_back(e);
  endtask

  // monitor: compare expectations at the negedge following their edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cyc < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard stale item cyc=%0d exp cyc=%0d", cyc, e.cyc);
      end else begin
        check_all("scb", e.rst_n, e.cause);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired cyc=%0d got=hung exp=done", cyc);
    report();
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 1'b0, 2'd1);

    // R1 power-on release
    @(negedge clk); b = cyc;
    rst_ni = 1'b1;
    push(b + T - 1, 1'b0, 2'd1);
    push(b + T, 1'b1, 2'd0);
    repeat (T + 5) @(negedge clk);

    // R4 glitch one sample short of acceptance
    b = cyc;
    mr_n = 1'b0;
    for (int k = 1; k <= 15; k++) push(b + k, 1'b1, 2'd0);
    repeat (ACC - 1) @(negedge clk);
    mr_n = 1'b1;
    repeat (20) @(negedge clk);

    // R4 R5 exact acceptance boundary, N = ACC
    b = cyc;
    mr_n = 1'b0;
    push(b + ACC + 2, 1'b1, 2'd0);
    push(b + ACC + 3, 1'b0, 2'd3);
    push(b + ACC + 2 + T, 1'b0, 2'd3);
    push(b + ACC + 3 + T, 1'b1, 2'd0);
    repeat (ACC) @(negedge clk);
    mr_n = 1'b1;
    repeat (T + 10) @(negedge clk);

    // R5 long press, N = 20
    b = cyc;
    mr_n = 1'b0;
    push(b + ACC + 3, 1'b0, 2'd3);
    push(b + 20 + 2 + T, 1'b0, 2'd3);
    push(b + 20 + 3 + T, 1'b1, 2'd0);
    repeat (20) @(negedge clk);
    mr_n = 1'b1;
    repeat (T + 10) @(negedge clk);

    // R2 short supply dip ignored
    b = cyc;
    supply_low = 1'b1;
    for (int k = 1; k <= 15; k++) push(b + k, 1'b1, 2'd0);
    repeat (Q - 1) @(negedge clk);
    supply_low = 1'b0;
    repeat (20) @(negedge clk);

    // R3 supply event, M = 10
    b = cyc;
    supply_low = 1'b1;
    push(b + Q, 1'b1, 2'd0);
    push(b + Q + 1, 1'b0, 2'd2);
    push(b + 10 + T, 1'b0, 2'd2);
    push(b + 11 + T, 1'b1, 2'd0);
    repeat (10) @(negedge clk);
    supply_low = 1'b0;
    repeat (T + 10) @(negedge clk);

    // R6 R7 retrigger: manual N = 10, supply M = 6 starting 30 cycles later
    b = cyc;
    mr_n = 1'b0;
    push(b + ACC + 3, 1'b0, 2'd3);
    push(b + 30 + Q, 1'b0, 2'd3);
    push(b + 30 + Q + 1, 1'b0, 2'd2);
    push(b + 13 + T, 1'b0, 2'd2);
    push(b + 36 + T, 1'b0, 2'd2);
    push(b + 37 + T, 1'b1, 2'd0);
    repeat (10) @(negedge clk);
    mr_n = 1'b1;
    repeat (20) @(negedge clk);
    supply_low = 1'b1;
    repeat (6) @(negedge clk);
    supply_low = 1'b0;
    repeat (T + 10) @(negedge clk);

    // R9 idle open-drain released
    check_all("R9 idle", 1'b1, 2'd0);
    while (q.size() > 0) @(negedge clk);
    report();
  end
endmodule